// File: doc/BRIEF.md
# DDR SDRAM Write Burst Generator

This block sits on the controller side of a DDR SDRAM interface and expands a single write command into a complete write burst. When a command is accepted, it captures the bank and column address. It also captures the burst-length code and the burst-type bit from its mode inputs. Later changes on those inputs have no effect on a burst in flight.

Each accepted burst is one fixed sequence of clock cycles:
- One command cycle, in which the strobe is held low as the preamble.
- BL/2 data cycles. In each, the strobe rises in the first half and falls in the second half. Each data cycle carries one rising-edge beat and one falling-edge beat of data and mask, together with the column address of each beat.
- One low postamble cycle.
- Release of the strobe and data drivers.

The user supplies beat pair j in the j-th cycle after the command edge. The first of these cycles is the command cycle on the memory side. A command that arrives while a burst is still running is dropped and reported with a one-cycle error pulse.

Top module: `ddr_wr_burst`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_we, dqs_oe, dq_oe, busy, err and dqs_pair are all 0.
- R2: A cmd_wr sampled with busy low is accepted. In the next cycle (the command cycle) mem_we is 1, mem_bank and mem_col show the address captured at that edge, dqs_oe and dq_oe are 1, and dqs_pair is 2'b00 (preamble). mem_bank and mem_col hold that address until the next accepted command.
- R3: The command cycle is followed by exactly BL/2 data cycles with dqs_pair = 2'b01 (bit 0 = strobe level in the first half-clock, bit 1 = level in the second half). The burst length BL is set by the mr_bl code: 2'b01 gives 2, 2'b10 gives 4, 2'b11 gives 8, and 2'b00 gives 2.
- R4: In data cycle j (j = 0 for the first), dq_rise, dq_fall, dm_rise and dm_fall equal the values on wd_rise, wd_fall, wm_rise and wm_fall in the j-th cycle after the command edge. Outside data cycles these outputs are 0.
- R5: With mr_bt = 0 (sequential), beat i of a burst with base column c has column (c − c mod BL) + ((c mod BL + i) mod BL). The rising beat of data cycle j is i = 2j, and the falling beat is i = 2j+1. Outside data cycles, col_rise and col_fall are 0.
- R6: With mr_bt = 1 (interleaved), beat i has column (c − c mod BL) + ((c mod BL) XOR i).
- R7: mr_bl, mr_bt, cmd_bank and cmd_col are sampled only at the accepting edge. Changing them later alters neither the beat columns nor mem_bank/mem_col of the running burst.
- R8: The cycle after the last data cycle is a postamble with dqs_pair = 2'b00 and both enables at 1. In the following cycle, dqs_oe and dq_oe are 0.
- R9: busy is 1 from the command cycle through the postamble cycle, and 0 otherwise.
- R10: A cmd_wr sampled while busy is 1 is ignored: the running burst continues unchanged and no mem_we is produced. err is 1 for exactly the following cycle.
- R11: A cmd_wr in the first cycle with busy low after a postamble is accepted, giving back-to-back bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write command request |
| cmd_bank | input | BANK_W | Bank address of the command |
| cmd_col | input | COL_W | Start column of the command |
| mr_bl | input | 2 | Burst length code |
| mr_bt | input | 1 | Burst type, 0 sequential, 1 interleaved |
| wd_rise | input | DQ_W | Rising-edge data of the current pair |
| wd_fall | input | DQ_W | Falling-edge data of the current pair |
| wm_rise | input | DM_W | Rising-edge mask of the current pair |
| wm_fall | input | DM_W | Falling-edge mask of the current pair |
| mem_we | output | 1 | Write command cycle toward the memory |
| mem_bank | output | BANK_W | Captured bank address |
| mem_col | output | COL_W | Captured column address |
| dqs_pair | output | 2 | Strobe levels for first and second half-clock |
| dqs_oe | output | 1 | Strobe output enable |
| dq_oe | output | 1 | Data and mask output enable |
| dq_rise | output | DQ_W | Rising-edge data beat |
| dq_fall | output | DQ_W | Falling-edge data beat |
| dm_rise | output | DM_W | Rising-edge mask beat |
| dm_fall | output | DM_W | Falling-edge mask beat |
| col_rise | output | COL_W | Column of the rising-edge beat |
| col_fall | output | COL_W | Column of the falling-edge beat |
| busy | output | 1 | Burst in progress |
| err | output | 1 | One-cycle pulse for a dropped command |

## Verification
Two functions can fall in the same cycle: rejection of a new command and the progress of the burst already running. The bench places a colliding cmd_wr, carrying deliberately different mode and address values, in every busy cycle of an eight-beat burst: preamble, each data cycle and the postamble. In the next cycle it requires err to pulse and every strobe, data and column value to match an undisturbed burst. Acceptance on the first idle cycle is judged against a back-to-back burst.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2,
    PH_POST = 2'd3
  } wr_phase_e;

  // Number of beats for a burst-length code; 00 falls back to two beats.
  function automatic logic [3:0] beats_of(input logic [1:0] code);
    case (code)
      2'b10:   beats_of = 4'd4;
      2'b11:   beats_of = 4'd8;
      default: beats_of = 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
  import ddr_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [1:0] bl_in,
  output wr_phase_e  ph_nxt,
  output logic [1:0] pair_nxt,
  output logic [1:0] bl_q,
  output logic       accept,
  output logic       reject
);

  wr_phase_e  ph_q;
  logic [1:0] pair_q;
  logic [1:0] last_pair;

  // Index of the final beat pair for the latched burst length.
  always_comb last_pair = 2'((beats_of(bl_q) >> 1) - 4'd1);

  always_comb begin
    ph_nxt   = ph_q;
    pair_nxt = pair_q;
    accept   = 1'b0;
    reject   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (cmd_wr) begin
          ph_nxt = PH_PRE;
          accept = 1'b1;
        end
      end
      PH_PRE: begin
        ph_nxt   = PH_DATA;
        pair_nxt = 2'd0;
      end
      PH_DATA: begin
        if (pair_q == last_pair) ph_nxt = PH_POST;
        else                     pair_nxt = 2'(pair_q + 2'd1);
      end
      PH_POST: ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
    if (cmd_wr && (ph_q != PH_IDLE)) reject = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      pair_q <= 2'd0;
      bl_q   <= 2'd0;
    end else begin
      ph_q   <= ph_nxt;
      pair_q <= pair_nxt;
      if (accept) bl_q <= bl_in;
    end
  end

endmodule

// File: rtl/ddr_wr_order.sv
module ddr_wr_order
  import ddr_wr_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic [COL_W-1:0] base_col,
  input  logic             burst_il,
  input  logic [1:0]       bl_code,
  input  logic [1:0]       pair,
  output logic [COL_W-1:0] col_rise,
  output logic [COL_W-1:0] col_fall
);

  localparam int LOW_W = 3;
  localparam int LANES = 2;

  logic [LOW_W-1:0] wrap_mask;
  logic [COL_W-1:0] lane_col [LANES];

  always_comb wrap_mask = 3'(beats_of(bl_code) - 4'd1);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] lo_seq;
    logic [LOW_W-1:0] lo_xor;
    logic [LOW_W-1:0] lo_sel;
    assign beat   = {pair, 1'(ln)};
    assign lo_seq = 3'(base_col[LOW_W-1:0] + beat) & wrap_mask;
    assign lo_xor = (base_col[LOW_W-1:0] ^ beat) & wrap_mask;
    assign lo_sel = burst_il ? lo_xor : lo_seq;
    assign lane_col[ln] = {base_col[COL_W-1:LOW_W],
                           (base_col[LOW_W-1:0] & ~wrap_mask) | lo_sel};
  end

  assign col_rise = lane_col[0];
  assign col_fall = lane_col[1];

endmodule

// File: rtl/ddr_wr_burst.sv
module ddr_wr_burst
  import ddr_wr_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 16,
  parameter int DM_W   = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [1:0]        mr_bl,
  input  logic              mr_bt,
  input  logic [DQ_W-1:0]   wd_rise,
  input  logic [DQ_W-1:0]   wd_fall,
  input  logic [DM_W-1:0]   wm_rise,
  input  logic [DM_W-1:0]   wm_fall,
  output logic              mem_we,
  output logic [BANK_W-1:0] mem_bank,
  output logic [COL_W-1:0]  mem_col,
  output logic [1:0]        dqs_pair,
  output logic              dqs_oe,
  output logic              dq_oe,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic [DM_W-1:0]   dm_rise,
  output logic [DM_W-1:0]   dm_fall,
  output logic [COL_W-1:0]  col_rise,
  output logic [COL_W-1:0]  col_fall,
  output logic              busy,
  output logic              err
);

  localparam logic [1:0] STROBE_TOGGLE = 2'b01;
  localparam logic [1:0] STROBE_LOW    = 2'b00;

  wr_phase_e        ph_nxt;
  logic [1:0]       pair_nxt;
  logic [1:0]       bl_q;
  logic             accept;
  logic             reject;
  logic             bt_q;
  logic [COL_W-1:0] ord_rise;
  logic [COL_W-1:0] ord_fall;
  logic             drive_nxt;
  logic             data_nxt;

  ddr_wr_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .bl_in    (mr_bl),
    .ph_nxt   (ph_nxt),
    .pair_nxt (pair_nxt),
    .bl_q     (bl_q),
    .accept   (accept),
    .reject   (reject)
  );

  ddr_wr_order #(.COL_W(COL_W)) u_order (
    .base_col (mem_col),
    .burst_il (bt_q),
    .bl_code  (bl_q),
    .pair     (pair_nxt),
    .col_rise (ord_rise),
    .col_fall (ord_fall)
  );

  assign drive_nxt = (ph_nxt != PH_IDLE);
  assign data_nxt  = (ph_nxt == PH_DATA);

  // Command capture and control outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we   <= 1'b0;
      mem_bank <= '0;
      mem_col  <= '0;
      bt_q     <= 1'b0;
      err      <= 1'b0;
      busy     <= 1'b0;
      dqs_oe   <= 1'b0;
      dq_oe    <= 1'b0;
    end else begin
      mem_we <= accept;
      err    <= reject;
      busy   <= drive_nxt;
      dqs_oe <= drive_nxt;
      dq_oe  <= drive_nxt;
      if (accept) begin
        mem_bank <= cmd_bank;
        mem_col  <= cmd_col;
        bt_q     <= mr_bt;
      end
    end
  end

  // Beat lanes: strobe, data, mask and beat columns.
  always_ff @(posedge clk) begin
    if (rst || !data_nxt) begin
      dqs_pair <= STROBE_LOW;
      dq_rise  <= '0;
      dq_fall  <= '0;
      dm_rise  <= '0;
      dm_fall  <= '0;
      col_rise <= '0;
      col_fall <= '0;
    end else begin
      dqs_pair <= STROBE_TOGGLE;
      dq_rise  <= wd_rise;
      dq_fall  <= wd_fall;
      dm_rise  <= wm_rise;
      dm_fall  <= wm_fall;
      col_rise <= ord_rise;
      col_fall <= ord_fall;
    end
  end

endmodule

// File: rtl/ddr_wr_chk.sv
module ddr_wr_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wr,
  input logic       mem_we,
  input logic [1:0] dqs_pair,
  input logic       dqs_oe,
  input logic       dq_oe,
  input logic       busy,
  input logic       err
);

  // R2
  cmd_preamble_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (dqs_oe && dq_oe && busy && dqs_pair == 2'b00));

  // R3
  first_edge_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (dqs_pair == 2'b01));

  // R8
  postamble_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_oe) |-> ($past(dqs_pair) == 2'b00));

  // R8
  released_chk: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe |-> (dqs_pair == 2'b00 && !dq_oe));

  // R10
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(cmd_wr && busy) && !mem_we));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy) |=> mem_we);

endmodule

bind ddr_wr_burst ddr_wr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_wr   (cmd_wr),
  .mem_we   (mem_we),
  .dqs_pair (dqs_pair),
  .dqs_oe   (dqs_oe),
  .dq_oe    (dq_oe),
  .busy     (busy),
  .err      (err)
);

// File: tb/tb_ddr_wr_burst.sv
module tb_ddr_wr_burst;

  localparam int COL_W  = 12;
  localparam int BANK_W = 2;
  localparam int DQ_W   = 16;
  localparam int DM_W   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_wr = 1'b0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic [1:0]        mr_bl = '0;
  logic              mr_bt = 1'b0;
  logic [DQ_W-1:0]   wd_rise = '0, wd_fall = '0;
  logic [DM_W-1:0]   wm_rise = '0, wm_fall = '0;
  logic              mem_we, dqs_oe, dq_oe, busy, err;
  logic [BANK_W-1:0] mem_bank;
  logic [COL_W-1:0]  mem_col, col_rise, col_fall;
  logic [1:0]        dqs_pair;
  logic [DQ_W-1:0]   dq_rise, dq_fall;
  logic [DM_W-1:0]   dm_rise, dm_fall;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr_wr_burst dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .mr_bl(mr_bl), .mr_bt(mr_bt), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wm_rise(wm_rise), .wm_fall(wm_fall), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_col(mem_col), .dqs_pair(dqs_pair), .dqs_oe(dqs_oe), .dq_oe(dq_oe),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .col_rise(col_rise), .col_fall(col_fall), .busy(busy), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pairs_of(input int code);
    return (code == 3) ? 4 : (code == 2) ? 2 : 1;
  endfunction

  function automatic int exp_col(input int c, input int code, input int bt, input int i);
    int bl = 2 * pairs_of(code);
    int lo = c % bl;
    int low = bt ? (lo ^ i) : ((lo + i) % bl);
    return c - lo + low;
  endfunction

  function automatic int pat_dr(input int s, input int j); return ((s & 255) << 8) | (j << 4) | 5; endfunction
  function automatic int pat_df(input int s, input int j); return ((~s & 255) << 8) | (j << 4) | 10; endfunction
  function automatic int pat_mr(input int s, input int j); return (s + j) & 3; endfunction
  function automatic int pat_mf(input int s, input int j); return ~(s + j) & 3; endfunction

  // Called just after a negedge: issues the command in the current cycle.
  task automatic burst(input int code, input int bt, input int col, input int bank,
                       input int coll, input int seed, input bit b2b);
    int n = pairs_of(code);
    cmd_wr = 1'b1; mr_bl = 2'(code); mr_bt = 1'(bt);
    cmd_col = COL_W'(col); cmd_bank = BANK_W'(bank);
    for (int k = 0; k <= n + 2; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R2 mem_we", int'(mem_we), 1);
        chk("R2 mem_col", int'(mem_col), col);
        chk("R2 mem_bank", int'(mem_bank), bank);
        if (b2b) chk("R11 back-to-back accept", int'(mem_we), 1);
      end else begin
        chk("R2 mem_we only once", int'(mem_we), 0);
      end
      chk("R9 busy", int'(busy), (k <= n + 1) ? 1 : 0);
      chk("R8 dqs_oe", int'(dqs_oe), (k <= n + 1) ? 1 : 0);
      chk("R8 dq_oe", int'(dq_oe), (k <= n + 1) ? 1 : 0);
      chk("R3 dqs_pair", int'(dqs_pair), (k >= 1 && k <= n) ? 1 : 0);
      chk("R10 err", int'(err), (coll >= 0 && k == coll + 1) ? 1 : 0);
      if (k >= 1 && k <= n) begin
        int j = k - 1;
        chk("R4 dq_rise", int'(dq_rise), pat_dr(seed, j));
        chk("R4 dq_fall", int'(dq_fall), pat_df(seed, j));
        chk("R4 dm_rise", int'(dm_rise), pat_mr(seed, j));
        chk("R4 dm_fall", int'(dm_fall), pat_mf(seed, j));
        chk(bt ? "R6 col_rise" : "R5 col_rise", int'(col_rise), exp_col(col, code, bt, 2 * j));
        chk(bt ? "R6 col_fall" : "R5 col_fall", int'(col_fall), exp_col(col, code, bt, 2 * j + 1));
      end else begin
        chk("R4 idle data", int'(dq_rise) | int'(dq_fall) | int'(dm_rise) | int'(dm_fall), 0);
        chk("R5 idle col", int'(col_rise) | int'(col_fall), 0);
      end
      if (k == n + 1) begin
        // R7: address held despite changed inputs after acceptance
        chk("R7 mem_col held", int'(mem_col), col);
        chk("R7 mem_bank held", int'(mem_bank), bank);
      end
      if (k <= n + 1) begin
        cmd_wr = (k == coll);
        mr_bl = ~2'(code); mr_bt = ~1'(bt);
        cmd_col = ~COL_W'(col); cmd_bank = ~BANK_W'(bank);
        wd_rise = (k < n) ? DQ_W'(pat_dr(seed, k)) : '0;
        wd_fall = (k < n) ? DQ_W'(pat_df(seed, k)) : '0;
        wm_rise = (k < n) ? DM_W'(pat_mr(seed, k)) : '0;
        wm_fall = (k < n) ? DM_W'(pat_mf(seed, k)) : '0;
      end else begin
        cmd_wr = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {27'd0, mem_we, dqs_oe, dq_oe, busy, err}, 0);
    chk("R1 reset dqs", int'(dqs_pair), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {27'd0, mem_we, dqs_oe, dq_oe, busy, err}, 0);
    for (int code = 0; code < 4; code++) begin
      for (int bt = 0; bt < 2; bt++) begin
        for (int lo = 0; lo < 8; lo++) begin
          int col = (lo * 37 + code * 512 + 8) & 12'hfff;
          col = (col & ~7) | lo;
          if (lo % 2 == 1) @(negedge clk);
          burst(code, bt, col, (lo + code) & 3, -1, code * 16 + bt * 8 + lo, lo % 2 == 0 && lo != 0);
        end
      end
    end
    // R10: collision in every busy cycle of an eight-beat burst
    for (int c = 0; c <= 5; c++) begin
      @(negedge clk);
      burst(3, c % 2, 12'h5a5 + c, c & 3, c, 200 + c, 1'b0);
    end
    burst(2, 1, 12'h0f3, 2, -1, 99, 1'b1);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule